// File: doc/BRIEF.md
# Mailbox Ring Scanning Engine

This block sits on the adapter side of a host-shared mailbox scheme. Two rings of four-byte entries live in host memory: an outbound ring that the host fills with requests, and an inbound ring that the engine fills with completions. The engine reaches both through a byte-wide memory request port. An init pulse loads the region base address and the entry count N. The outbound ring takes the first N entries of the region and the inbound ring takes the next N.

A start strobe wakes the scanner. The scanner walks the outbound ring from its saved index. For every live entry it reads the 24-bit control block pointer, hands the pointer to an execution port and writes the entry's command byte back to free. Completions come back from the execution side as a status byte and a pointer. The engine writes each one into the next inbound entry, but only once the host has released that entry. It then raises a mailbox-in interrupt flag, which stays set until the host clears it.

Top module: `mbox_ring_engine`

## Requirements
- R1: While reset is held and just after it, mem_req_o, exec_valid_o, done_ready_o and irq_o are all low. The engine never drives exec_valid_o and mem_req_o in the same cycle.
- R2: Each entry is 4 bytes. Byte 0 is the command or status byte and bytes 1..3 hold the pointer, most significant byte first. Outbound entry i sits at base+4*i and inbound entry i sits at base+4*N+4*i.
- R3: An outbound entry with command 0x01 is passed on exec_ptr_o with exec_abort_o=0. The outputs stay stable until exec_ready_i, and the command byte is then written to 0x00.
- R4: An outbound entry with command 0x02 is passed in the same way with exec_abort_o=1 and is then freed.
- R5: A scan stops at the first outbound entry whose command is neither 0x01 nor 0x02. That entry is left unwritten, and the next start strobe resumes at that same entry.
- R6: The outbound index wraps from entry N-1 back to entry 0.
- R7: A completion writes pointer bytes 1..3 and then the status byte into the current inbound entry. done_ready_o is high exactly in the cycle the status byte write is accepted.
- R8: The inbound index wraps from entry N-1 back to entry 0.
- R9: If the current inbound entry's command byte is not 0x00, nothing is written to that entry and the completion stays pending until the host writes 0x00 there. Outbound scanning keeps running while the completion waits.
- R10: irq_o sets in the cycle after a status write is accepted and clears in the cycle after irq_clr_i. A set in the same cycle wins over a clear.
- R11: init_i loads the base and N, returns both indices to entry 0 and drops any pending scan.
- R12: Once mem_req_o is raised, the request stays high with a stable address, direction and write data until mem_ack_i. Read data is taken in the cycle of mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load region base and count, reset indices |
| init_base_i | input | ADDR_W | Region base address |
| init_count_i | input | IDX_W | Entries per ring (N, at least 1) |
| start_i | input | 1 | Scan request strobe |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Access accepted; read data valid |
| mem_rdata_i | input | 8 | Read data |
| exec_valid_o | output | 1 | Control block offered for execution |
| exec_ready_i | input | 1 | Execution side accepts |
| exec_abort_o | output | 1 | Offered entry is an abort request |
| exec_ptr_o | output | 24 | Control block pointer |
| done_valid_i | input | 1 | Completion pending |
| done_ready_o | output | 1 | Completion posted this cycle |
| done_status_i | input | 8 | Inbound status code (0x01..0x04) |
| done_ptr_i | input | 24 | Pointer of the completed block |
| irq_o | output | 1 | Mailbox-in full interrupt flag |
| irq_clr_i | input | 1 | Clear interrupt flag |

## Verification
The first scan mixes start and abort entries ahead of a free entry. This separates correct abort flagging and freeing from a scan that runs past the stop point. A second scan places live entries across the ring end and then hits an unknown command code. It tells wrapping apart from restarting at zero, and shows that the stop entry is left untouched and resumed from. The completions walk all inbound entries and wrap. A busy inbound entry held during a concurrent scan separates correct back-pressure from overwriting or starving the scanner. A re-init to a smaller ring checks that both indices and the inbound offset follow the new count.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int PTR_W = 24;

  localparam logic [7:0] CMD_FREE  = 8'h00;
  localparam logic [7:0] CMD_START = 8'h01;
  localparam logic [7:0] CMD_ABORT = 8'h02;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OB_CMD,
    S_OB_P0,
    S_OB_P1,
    S_OB_P2,
    S_DISP,
    S_OB_FREE,
    S_IB_CHK,
    S_IB_P0,
    S_IB_P1,
    S_IB_P2,
    S_IB_ST
  } mbox_state_e;
endpackage

// File: rtl/mbox_ring_idx.sv
module mbox_ring_idx #(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_o <= '0;
    else if (clr_i)    idx_o <= '0;
    else if (adv_i)    idx_o <= (idx_o == last_i) ? '0 : idx_o + IDX_W'(1);
  end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/mbox_ring_engine.sv
module mbox_ring_engine
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic [ADDR_W-1:0]   init_base_i,
  input  logic [IDX_W-1:0]    init_count_i,
  input  logic                start_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [7:0]          mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [7:0]          mem_rdata_i,
  output logic                exec_valid_o,
  input  logic                exec_ready_i,
  output logic                exec_abort_o,
  output logic [PTR_W-1:0]    exec_ptr_o,
  input  logic                done_valid_i,
  output logic                done_ready_o,
  input  logic [7:0]          done_status_i,
  input  logic [PTR_W-1:0]    done_ptr_i,
  output logic                irq_o,
  input  logic                irq_clr_i
);
  localparam int OFF_W = IDX_W + 3;

  mbox_state_e       state_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              scan_pend_q;
  logic              ib_busy_q;
  logic [7:0]        cmd_q;
  logic [PTR_W-1:0]  ptr_q;

  logic [IDX_W-1:0]  ob_idx, ib_idx, last_idx, idx_sel;
  logic              ob_adv, ib_adv;
  logic              ib_sel;
  logic [1:0]        byte_sel;
  logic              rd_live;
  logic [IDX_W+1:0]  ring_off;
  logic [OFF_W-1:0]  off_sum;

  assign last_idx = cnt_q - IDX_W'(1);
  assign rd_live  = (mem_rdata_i == CMD_START) || (mem_rdata_i == CMD_ABORT);
  assign ob_adv   = (state_q == S_OB_FREE) && mem_ack_i;
  assign ib_adv   = (state_q == S_IB_ST) && mem_ack_i;

  mbox_ring_idx #(.IDX_W(IDX_W)) u_ob_idx (
    .clk_i, .rst_ni, .clr_i(init_i), .adv_i(ob_adv), .last_i(last_idx), .idx_o(ob_idx)
  );

  mbox_ring_idx #(.IDX_W(IDX_W)) u_ib_idx (
    .clk_i, .rst_ni, .clr_i(init_i), .adv_i(ib_adv), .last_i(last_idx), .idx_o(ib_idx)
  );

  mbox_irq_flag u_irq (
    .clk_i, .rst_ni, .set_i(ib_adv), .clr_i(irq_clr_i), .flag_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      base_q      <= '0;
      cnt_q       <= IDX_W'(1);
      scan_pend_q <= 1'b0;
      ib_busy_q   <= 1'b0;
      cmd_q       <= CMD_FREE;
      ptr_q       <= '0;
    end else if (init_i) begin
      state_q     <= S_IDLE;
      base_q      <= init_base_i;
      cnt_q       <= init_count_i;
      scan_pend_q <= 1'b0;
      ib_busy_q   <= 1'b0;
    end else begin
      if (start_i)
        scan_pend_q <= 1'b1;
      else if (state_q == S_OB_CMD && mem_ack_i && !rd_live)
        scan_pend_q <= 1'b0;

      case (state_q)
        S_IDLE: begin
          // a blocked completion yields one entry slot to a waiting scan
          if (done_valid_i && !(ib_busy_q && scan_pend_q)) begin
            state_q <= S_IB_CHK;
          end else if (scan_pend_q) begin
            state_q   <= S_OB_CMD;
            ib_busy_q <= 1'b0;
          end
        end
        S_OB_CMD: if (mem_ack_i) begin
          cmd_q   <= mem_rdata_i;
          state_q <= rd_live ? S_OB_P0 : S_IDLE;
        end
        S_OB_P0: if (mem_ack_i) begin
          ptr_q[23:16] <= mem_rdata_i;
          state_q      <= S_OB_P1;
        end
        S_OB_P1: if (mem_ack_i) begin
          ptr_q[15:8] <= mem_rdata_i;
          state_q     <= S_OB_P2;
        end
        S_OB_P2: if (mem_ack_i) begin
          ptr_q[7:0] <= mem_rdata_i;
          state_q    <= S_DISP;
        end
        S_DISP:    if (exec_ready_i) state_q <= S_OB_FREE;
        S_OB_FREE: if (mem_ack_i)    state_q <= S_IDLE;
        S_IB_CHK: if (mem_ack_i) begin
          if (mem_rdata_i == CMD_FREE) begin
            state_q <= S_IB_P0;
          end else begin
            ib_busy_q <= 1'b1;
            state_q   <= S_IDLE;
          end
        end
        S_IB_P0: if (mem_ack_i) state_q <= S_IB_P1;
        S_IB_P1: if (mem_ack_i) state_q <= S_IB_P2;
        S_IB_P2: if (mem_ack_i) state_q <= S_IB_ST;
        S_IB_ST: if (mem_ack_i) begin
          ib_busy_q <= 1'b0;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_wdata_o = 8'h00;
    ib_sel      = 1'b0;
    byte_sel    = 2'd0;
    case (state_q)
      S_OB_CMD:  byte_sel = 2'd0;
      S_OB_P0:   byte_sel = 2'd1;
      S_OB_P1:   byte_sel = 2'd2;
      S_OB_P2:   byte_sel = 2'd3;
      S_OB_FREE: begin mem_we_o = 1'b1; mem_wdata_o = CMD_FREE; end
      S_IB_CHK:  ib_sel = 1'b1;
      S_IB_P0:   begin ib_sel = 1'b1; byte_sel = 2'd1; mem_we_o = 1'b1; mem_wdata_o = done_ptr_i[23:16]; end
      S_IB_P1:   begin ib_sel = 1'b1; byte_sel = 2'd2; mem_we_o = 1'b1; mem_wdata_o = done_ptr_i[15:8]; end
      S_IB_P2:   begin ib_sel = 1'b1; byte_sel = 2'd3; mem_we_o = 1'b1; mem_wdata_o = done_ptr_i[7:0]; end
      S_IB_ST:   begin ib_sel = 1'b1; mem_we_o = 1'b1; mem_wdata_o = done_status_i; end
      default:   mem_req_o = 1'b0;
    endcase
  end

  assign idx_sel    = ib_sel ? ib_idx : ob_idx;
  assign ring_off   = ib_sel ? {cnt_q, 2'b00} : '0;
  assign off_sum    = OFF_W'(ring_off) + OFF_W'({idx_sel, 2'b00}) + OFF_W'(byte_sel);
  assign mem_addr_o = base_q + ADDR_W'(off_sum);

  assign exec_valid_o = (state_q == S_DISP);
  assign exec_abort_o = (cmd_q == CMD_ABORT);
  assign exec_ptr_o   = ptr_q;
  assign done_ready_o = ib_adv;
endmodule

// File: rtl/mbox_ring_engine_chk.sv
module mbox_ring_engine_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o,
  input logic              mem_ack_i,
  input logic              exec_valid_o,
  input logic              exec_ready_i,
  input logic              exec_abort_o,
  input logic [23:0]       exec_ptr_o,
  input logic              done_valid_i,
  input logic              done_ready_o,
  input logic              irq_o,
  input logic              irq_clr_i
);
  a_r1_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o |-> !mem_req_o);

  a_r3_exec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o && !exec_ready_i && !init_i |=>
      exec_valid_o && $stable(exec_ptr_o) && $stable(exec_abort_o));

  a_r7_post_is_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ready_o |-> mem_req_o && mem_we_o && mem_ack_i && done_valid_i);

  a_r10_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_i && done_ready_o |=> irq_o);

  a_r10_irq_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !(done_valid_i && done_ready_o) |=> !irq_o);

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !init_i |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
endmodule

bind mbox_ring_engine mbox_ring_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .exec_valid_o(exec_valid_o), .exec_ready_i(exec_ready_i),
  .exec_abort_o(exec_abort_o), .exec_ptr_o(exec_ptr_o),
  .done_valid_i(done_valid_i), .done_ready_o(done_ready_o),
  .irq_o(irq_o), .irq_clr_i(irq_clr_i)
);

// File: tb/mbox_ring_engine_bench.sv
`timescale 1ns/1ps
module mbox_ring_engine_bench;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              init_i = 1'b0;
  logic [ADDR_W-1:0] init_base = '0;
  logic [IDX_W-1:0]  init_count = '0;
  logic              start_i = 1'b0;
  logic              mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              exec_valid, exec_ready, exec_abort;
  logic [23:0]       exec_ptr;
  logic              done_valid = 1'b0;
  logic              done_ready;
  logic [7:0]        done_status = '0;
  logic [23:0]       done_ptr = '0;
  logic              irq;
  logic              irq_clr = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int posted = 0;

  logic [7:0]  mem [256];
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [7:0]  host_data = '0;
  logic [24:0] exp_q [$];
  logic        irq_m = 1'b0;
  logic        prev_hold = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;

  mbox_ring_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mbox_ring_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .init_i(init_i), .init_base_i(init_base), .init_count_i(init_count),
    .start_i(start_i),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .exec_valid_o(exec_valid), .exec_ready_i(exec_ready),
    .exec_abort_o(exec_abort), .exec_ptr_o(exec_ptr),
    .done_valid_i(done_valid), .done_ready_o(done_ready),
    .done_status_i(done_status), .done_ptr_i(done_ptr),
    .irq_o(irq), .irq_clr_i(irq_clr)
  );

  // host memory: one-cycle acknowledge, host writes applied by the same process
  always @(posedge clk) begin
    cyc        <= cyc + 1;
    exec_ready <= (cyc % 4) != 3;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      end else begin
        mem_ack <= 1'b0;
      end
      if (host_we) mem[host_addr] <= host_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle reference comparison
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      chk("R10 irq flag", 32'(irq), 32'(irq_m));
      if (done_valid && done_ready) irq_m = 1'b1;
      else if (irq_clr)             irq_m = 1'b0;
      if (exec_valid && exec_ready) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R3 unexpected dispatch actual=%h expected=none", {exec_abort, exec_ptr});
        end else begin
          logic [24:0] e;
          e = exp_q.pop_front();
          chk("R3/R4 dispatch", 32'({exec_abort, exec_ptr}), 32'(e));
        end
      end
      if (prev_hold && !init_i)
        chk("R12 request hold", 32'({mem_req, mem_addr}), 32'({1'b1, prev_addr}));
      prev_hold = mem_req && !mem_ack && !init_i;
      prev_addr = mem_addr;
    end
  end

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic wr_ent(input logic [7:0] a, input logic [7:0] c, input logic [23:0] p);
    host_wr(a + 8'd1, p[23:16]);
    host_wr(a + 8'd2, p[15:8]);
    host_wr(a + 8'd3, p[7:0]);
    host_wr(a, c);
  endtask

  task automatic pulse_start();
    @(negedge clk); #1; start_i = 1'b1;
    @(negedge clk); #1; start_i = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); #1; irq_clr = 1'b1;
    @(negedge clk); #1; irq_clr = 1'b0;
  endtask

  task automatic do_init(input logic [ADDR_W-1:0] b, input logic [IDX_W-1:0] n);
    @(negedge clk); #1; init_i = 1'b1; init_base = b; init_count = n;
    @(negedge clk); #1; init_i = 1'b0;
  endtask

  task automatic post_done(input logic [7:0] st, input logic [23:0] p);
    @(negedge clk); #1;
    done_valid = 1'b1; done_status = st; done_ptr = p;
    do begin
      @(negedge clk); #2;
    end while (!done_ready);
    @(negedge clk); #1;
    done_valid = 1'b0;
    posted++;
  endtask

  task automatic chk_ent(input string tag, input logic [7:0] a, input logic [7:0] c, input logic [23:0] p);
    chk(tag, 32'({mem[a], mem[a+8'd1], mem[a+8'd2], mem[a+8'd3]}), 32'({c, p}));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset outputs", 32'({mem_req, exec_valid, done_ready, irq}), 32'(0));
    rst_n = 1'b1;
    idle(2);
    chk("R1 idle after reset", 32'({mem_req, exec_valid, done_ready, irq}), 32'(0));

    do_init(24'h000040, 8'd4);

    // R3 R4 R5: start, abort, start, then free stops the scan
    wr_ent(8'h40, 8'h01, 24'h123456);
    wr_ent(8'h44, 8'h02, 24'hABCDEF);
    wr_ent(8'h48, 8'h01, 24'h000102);
    exp_q.push_back({1'b0, 24'h123456});
    exp_q.push_back({1'b1, 24'hABCDEF});
    exp_q.push_back({1'b0, 24'h000102});
    pulse_start();
    idle(80);
    chk("R3 dispatch queue drained", 32'(exp_q.size()), 32'(0));
    chk_ent("R3 entry0 freed, pointer kept (R2)", 8'h40, 8'h00, 24'h123456);
    chk_ent("R4 abort entry freed", 8'h44, 8'h00, 24'hABCDEF);
    chk_ent("R3 entry2 freed", 8'h48, 8'h00, 24'h000102);

    // R6 wrap, R5 stop at unknown code and resume there
    wr_ent(8'h4C, 8'h01, 24'h333333);
    wr_ent(8'h40, 8'h01, 24'h444444);
    wr_ent(8'h44, 8'h07, 24'h999999);
    exp_q.push_back({1'b0, 24'h333333});
    exp_q.push_back({1'b0, 24'h444444});
    pulse_start();
    idle(80);
    chk("R6 wrapped dispatch drained", 32'(exp_q.size()), 32'(0));
    chk_ent("R5 unknown code left untouched", 8'h44, 8'h07, 24'h999999);
    wr_ent(8'h44, 8'h01, 24'h555555);
    exp_q.push_back({1'b0, 24'h555555});
    pulse_start();
    idle(60);
    chk("R5 resumed at stop entry", 32'(exp_q.size()), 32'(0));
    chk_ent("R5 resumed entry freed", 8'h44, 8'h00, 24'h555555);

    // R7 R10: first completion at base+4N
    post_done(8'h01, 24'hA1A2A3);
    idle(2);
    chk_ent("R7 inbound entry0 written (R2)", 8'h50, 8'h01, 24'hA1A2A3);
    chk("R10 irq set after post", 32'(irq), 32'(1));
    pulse_clr();
    idle(1);
    chk("R10 irq cleared", 32'(irq), 32'(0));
    host_wr(8'h50, 8'h00);
    post_done(8'h04, 24'hB1B2B3);
    post_done(8'h02, 24'hC1C2C3);
    post_done(8'h03, 24'hD1D2D3);
    idle(2);
    chk_ent("R7 inbound entry1", 8'h54, 8'h04, 24'hB1B2B3);
    chk_ent("R7 inbound entry2", 8'h58, 8'h02, 24'hC1C2C3);
    chk_ent("R7 inbound entry3", 8'h5C, 8'h03, 24'hD1D2D3);
    post_done(8'h01, 24'hE1E2E3);
    idle(2);
    chk_ent("R8 inbound wrapped to entry0", 8'h50, 8'h01, 24'hE1E2E3);

    // R9: next inbound entry (1) still owned by host; scan must proceed meanwhile
    chk("R9 posts so far", 32'(posted), 32'(5));
    fork
      post_done(8'h01, 24'h777777);
    join_none
    wr_ent(8'h48, 8'h01, 24'h666666);
    exp_q.push_back({1'b0, 24'h666666});
    pulse_start();
    idle(60);
    chk("R9 completion held", 32'(posted), 32'(5));
    chk_ent("R9 busy entry not overwritten", 8'h54, 8'h04, 24'hB1B2B3);
    chk("R9 scan not starved", 32'(exp_q.size()), 32'(0));
    host_wr(8'h54, 8'h00);
    idle(40);
    chk("R9 completion released", 32'(posted), 32'(6));
    chk_ent("R9 entry written after release", 8'h54, 8'h01, 24'h777777);

    // R11: re-init with a new base and N=2
    do_init(24'h000080, 8'd2);
    wr_ent(8'h80, 8'h01, 24'h818283);
    wr_ent(8'h84, 8'h02, 24'h858687);
    exp_q.push_back({1'b0, 24'h818283});
    exp_q.push_back({1'b1, 24'h858687});
    pulse_start();
    idle(80);
    chk("R11 scan from new entry0 and wrap at N", 32'(exp_q.size()), 32'(0));
    chk_ent("R11 entry0 freed", 8'h80, 8'h00, 24'h818283);
    post_done(8'h04, 24'h0C0D0E);
    idle(2);
    chk_ent("R11 inbound index reset, ring at base+8", 8'h88, 8'h04, 24'h0C0D0E);

    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule